// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compares

This block is the combinational integer arithmetic-logic unit of a small load/store RISC datapath. It takes two operands, a shift distance and a 4-bit operation select. It returns a result word and a zero flag. The branch unit uses the zero flag after a subtract to decide equal and not-equal branches.

The operations are wrapping add and subtract, bitwise AND, OR and NOR, logical shifts in both directions, and set-less-than in a signed and an unsigned form. Bitwise inversion has no operation of its own: NOR with a zero operand gives it. The two compares can give opposite answers for the same bit patterns. The signed compare takes the true sign of the difference, which is the difference's top bit XORed with the overflow bit. The unsigned compare takes the borrow of the same subtraction.

The word width is a parameter and defaults to 32 bits. The shift-amount width is derived from it: 5 bits at the default.

Top module: `rvx_alu`

## Requirements
- R1: Code 0 (add) gives opnd_a + opnd_b modulo 2^WIDTH; there is no overflow output and no exception.
- R2: Code 1 (subtract) gives opnd_a - opnd_b modulo 2^WIDTH.
- R3: Code 2 gives the bitwise AND of the operands, and code 3 gives the bitwise OR.
- R4: Code 4 gives ~(opnd_a | opnd_b); with opnd_b = 0 the result is the bitwise NOT of opnd_a.
- R5: Code 5 shifts opnd_a left by shamt places and fills the vacated low bits with zeros.
- R6: Code 6 shifts opnd_a right by shamt places and fills the vacated high bits with zeros.
- R7: Code 7 gives 1 when opnd_a < opnd_b as two's-complement numbers and 0 otherwise, zero-extended to the full width. The answer stays correct when opnd_a - opnd_b overflows (for example, 0x80000000 versus 0x00000001 gives 1).
- R8: Code 8 gives 1 when opnd_a < opnd_b as unsigned numbers and 0 otherwise, zero-extended. For 0xFFFFFFFF versus 0x00000001, code 8 gives 0 and code 7 gives 1.
- R9: zero is 1 exactly when every bit of result is 0, for every operation code.
- R10: Codes 9 to 15 give a result of 0, whatever the operands.
- R11: shamt has no effect on the result of any code other than 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand; the minuend for subtract and the value shifted for shifts |
| opnd_b | input | WIDTH | Second operand |
| shamt | input | $clog2(WIDTH) | Shift distance for codes 5 and 6 |
| op_sel | input | 4 | Operation select code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The zero flag and a compare or subtract result land in the same evaluation. A subtract of equal operands, or a set-less-than whose answer is false, returns an all-zero word, so the flag must rise in the same cycle as that result.

The bench provokes these cases two ways. It sweeps every code, operand pair and shift distance on a 4-bit instance. On the 32-bit instance it drives equal operands and the sign-boundary pairs where overflow and borrow disagree.

Each result and each flag is judged against an arithmetic model in the bench. The model compares numbers after sign extension and ignores bit patterns. For codes other than 5 and 6, the bench repeats the vector with a different shamt and expects the same result.

// File: rtl/rvx_alu_pkg.sv
package rvx_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SLT  = 4'd7,
        OP_SLTU = 4'd8
    } alu_op_e;

    // Flags produced by the shared adder.
    typedef struct packed {
        logic carry;   // carry out of the top bit; for a - b, 1 means no borrow
        logic ovf;     // two's-complement overflow
        logic neg;     // top bit of the sum
    } arith_flags_t;

    // Decoded controls for one operation.
    typedef struct packed {
        logic invert_b;
        logic shift_right;
        logic valid;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [3:0] code);
        op_ctrl_t c;
        c.invert_b    = (code == OP_SUB) || (code == OP_SLT) || (code == OP_SLTU);
        c.shift_right = (code == OP_SRL);
        c.valid       = (code <= OP_SLTU);
        return c;
    endfunction

    function automatic logic signed_less(input arith_flags_t f);
        return f.neg ^ f.ovf;
    endfunction

    function automatic logic unsigned_less(input arith_flags_t f);
        return ~f.carry;
    endfunction

endpackage

// File: rtl/rvx_alu_addsub.sv
module rvx_alu_addsub
    import rvx_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output arith_flags_t     flags
);
    localparam int EXT = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic [EXT-1:0]   full;

    always_comb begin
        b_eff = b ^ {WIDTH{sub}};
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = full[WIDTH-1:0];
        flags.carry = full[WIDTH];
        flags.neg   = full[WIDTH-1];
        flags.ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (full[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/rvx_alu_logic.sv
module rvx_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o
);
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        nor_o = ~or_o;
    end
endmodule

// File: rtl/rvx_alu_shift.sv
module rvx_alu_shift #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    input  logic             right,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] din_rev;
    logic [WIDTH-1:0] stage [SHW+1];
    logic [WIDTH-1:0] res_rev;

    // One left shifter serves both directions: a right shift mirrors the word before and after it.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign din_rev[i] = din[WIDTH-1-i];
        assign res_rev[i] = stage[SHW][WIDTH-1-i];
    end

    assign stage[0] = right ? din_rev : din;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign dout = right ? res_rev : stage[SHW];
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
    import rvx_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SHW-1:0]   shamt,
    input  logic [3:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    op_ctrl_t         ctrl;
    logic [WIDTH-1:0] sum;
    arith_flags_t     flags;
    logic [WIDTH-1:0] and_v, or_v, nor_v, shift_v;

    assign ctrl = decode_op(op_sel);

    rvx_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(ctrl.invert_b), .sum(sum), .flags(flags)
    );

    rvx_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(opnd_a), .b(opnd_b), .and_o(and_v), .or_o(or_v), .nor_o(nor_v)
    );

    rvx_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .din(opnd_a), .amt(shamt), .right(ctrl.shift_right), .dout(shift_v)
    );

    always_comb begin
        result = '0;
        if (ctrl.valid) begin
            case (op_sel)
                OP_ADD, OP_SUB: result = sum;
                OP_AND:         result = and_v;
                OP_OR:          result = or_v;
                OP_NOR:         result = nor_v;
                OP_SLL, OP_SRL: result = shift_v;
                OP_SLT:         result = {{(WIDTH-1){1'b0}}, signed_less(flags)};
                OP_SLTU:        result = {{(WIDTH-1){1'b0}}, unsigned_less(flags)};
                default:        result = '0;
            endcase
        end
        zero = ~|result;
    end
endmodule

// File: rtl/rvx_alu_chk.sv
module rvx_alu_chk
    import rvx_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [SHW-1:0]   shamt,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero
);
    localparam int MSB = WIDTH - 1;

    logic known;
    assign known = !$isunknown({opnd_a, opnd_b, shamt, op_sel});

    always_comb begin
        if (known) begin
            // R9: the flag agrees with the word
            a_r9_zero_flag: assert (zero == (result == '0))
                else $error("zero flag disagrees with result");
            // R1: subtracting b from the sum gives back a
            if (op_sel == OP_ADD)
                a_r1_add_inverse: assert (WIDTH'(result - opnd_b) == opnd_a)
                    else $error("add result inconsistent");
            // R4: NOR result is disjoint from the OR and complements it
            if (op_sel == OP_NOR)
                a_r4_nor_cover: assert (((result & (opnd_a | opnd_b)) == '0) &&
                                        ((result | opnd_a | opnd_b) == '1))
                    else $error("nor result inconsistent");
            // R7: operands with different signs are ordered by the sign of a
            if (op_sel == OP_SLT && opnd_a[MSB] != opnd_b[MSB])
                a_r7_sign_order: assert (result == {{MSB{1'b0}}, opnd_a[MSB]})
                    else $error("signed compare wrong across signs");
            // R8: operands with different top bits are ordered by the top bit of b
            if (op_sel == OP_SLTU && opnd_a[MSB] != opnd_b[MSB])
                a_r8_top_order: assert (result == {{MSB{1'b0}}, opnd_b[MSB]})
                    else $error("unsigned compare wrong across top bits");
            // R10: unused codes return nothing
            if (op_sel > OP_SLTU)
                a_r10_unused_zero: assert (result == '0)
                    else $error("unused code gave nonzero result");
        end
    end
endmodule

bind rvx_alu rvx_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
    .op_sel(op_sel), .result(result), .zero(zero)
);

// File: tb/sim_rvx_alu.sv
`timescale 1ns/1ps
module sim_rvx_alu;
    localparam int W  = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [W-1:0]  a, b, res;
    logic [4:0]    sh;
    logic [3:0]    op;
    logic          zf;
    logic [SW-1:0] sa, sb, sres;
    logic [1:0]    ssh;
    logic [3:0]    sop;
    logic          szf;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    rvx_alu #(.WIDTH(W)) u0 (
        .opnd_a(a), .opnd_b(b), .shamt(sh), .op_sel(op), .result(res), .zero(zf)
    );
    rvx_alu #(.WIDTH(SW)) u_small (
        .opnd_a(sa), .opnd_b(sb), .shamt(ssh), .op_sel(sop), .result(sres), .zero(szf)
    );

    function automatic string tag_of(input logic [3:0] code);
        case (code)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic longint unsigned model(input int w, input logic [3:0] code,
                                              input longint unsigned x, input longint unsigned y,
                                              input int s);
        longint unsigned m = (64'd1 << w) - 1;
        longint sx = (x >> (w-1)) != 0 ? longint'(x) - longint'(64'd1 << w) : longint'(x);
        longint sy = (y >> (w-1)) != 0 ? longint'(y) - longint'(64'd1 << w) : longint'(y);
        case (code)
            4'd0: return (x + y) & m;
            4'd1: return (x - y) & m;
            4'd2: return x & y;
            4'd3: return x | y;
            4'd4: return ~(x | y) & m;
            4'd5: return (x << s) & m;
            4'd6: return x >> s;
            4'd7: return (sx < sy) ? 1 : 0;
            4'd8: return (x < y) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input longint unsigned got, input longint unsigned exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d got=%h exp=%h", tag, op, a, b, sh, got, exp);
        end
    endtask

    task automatic run32(input logic [3:0] code, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [4:0] s);
        longint unsigned e;
        logic [W-1:0] first;
        op = code; a = x; b = y; sh = s;
        #2;
        e = model(W, code, x, y, int'(s));
        check(tag_of(code), res, e);
        check("R9", zf, (e == 0));
        if (code != 4'd5 && code != 4'd6) begin
            first = res;
            sh = ~s;
            #2;
            check("R11", res, first);
        end
    endtask

    initial begin
        a = '0; b = '0; sh = '0; op = '0;
        sa = '0; sb = '0; ssh = '0; sop = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // quiet state after reset: add of zeros
        check("R9", zf, 1);
        check("R1", res, 0);

        // corners on the full-width instance
        run32(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd3);   // R1 wrap to zero
        run32(4'd1, 32'h0000_0000, 32'h0000_0001, 5'd0);   // R2 wrap below zero
        run32(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd7);   // R2 equal, R9 zero
        run32(4'd2, 32'h0000_0DC0, 32'h0000_3C00, 5'd1);   // R3
        run32(4'd3, 32'h0000_0DC0, 32'h0000_3C00, 5'd1);   // R3
        run32(4'd4, 32'h0000_3C00, 32'h0000_0000, 5'd2);   // R4 plain NOT
        run32(4'd5, 32'h8000_0001, 32'h0, 5'd31);          // R5
        run32(4'd6, 32'h8000_0001, 32'h0, 5'd31);          // R6
        run32(4'd7, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);   // R7 gives 1
        run32(4'd8, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);   // R8 gives 0
        run32(4'd7, 32'h8000_0000, 32'h0000_0001, 5'd0);   // R7 overflowing difference
        run32(4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);   // R7 overflowing difference
        run32(4'd7, 32'h0000_0005, 32'h0000_0005, 5'd0);   // R7 equal gives 0, R9
        run32(4'd15, 32'hDEAD_BEEF, 32'h1, 5'd4);          // R10
        run32(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);   // R10

        // random operands on every code, 32-bit
        for (int code = 0; code < 16; code++) begin
            for (int n = 0; n < 200; n++) begin
                run32(4'(code), $urandom(), $urandom(), 5'($urandom()));
            end
        end

        // exhaustive sweep on the 4-bit instance
        for (int code = 0; code < 16; code++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int s = 0; s < 4; s++) begin
                        longint unsigned e;
                        sop = 4'(code); sa = 4'(x); sb = 4'(y); ssh = 2'(s);
                        #1;
                        e = model(SW, 4'(code), longint'(x), longint'(y), s);
                        nchk++;
                        if (sres !== 4'(e)) begin
                            nerr++;
                            $display("FAIL %s small op=%0d a=%0d b=%0d sh=%0d got=%h exp=%h",
                                     tag_of(4'(code)), code, x, y, s, sres, e);
                        end
                        nchk++;
                        if (szf !== (e == 0)) begin
                            nerr++;
                            $display("FAIL R9 small op=%0d a=%0d b=%0d got=%b exp=%b",
                                     code, x, y, szf, (e == 0));
                        end
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired got=%0d exp=below 150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule